// File: doc/BRIEF.md
# BCD calendar RTC core

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, weekday, day of month, month and a two-digit year counted from 1970. It advances once per second. The second is produced by dividing a 32768 Hz enable input down with a prescaler. Day-of-month rollover follows the month length. February length is set by a leap flag that travels with the year field. The flag is recomputed by the block each time the year advances.

Software talks to the block through a small strobed register port. Writes to the seven time fields land in shadow registers only. The live counters take all seven shadow fields at once when software sets the trigger bit of the commit register, so a new time never appears half-written. A control bit chooses between a 24-hour clock and a 12-hour clock with a PM flag. Reads always return the live counters, one cycle after the read strobe.

Top module: `bcd_cal_rtc`

## Requirements
- R1: After reset the live fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0, day 0x01, month 0x01 and year 0x0000, and the control register reads 0x0001 (24-hour mode).
- R2: The seconds field advances once for every TICK_DIV clock cycles in which tick_32k is high. A commit clears the prescaler, so the first second after a commit needs a full TICK_DIV enables.
- R3: Seconds and minutes count BCD 00 to 59 and wrap to 00 with a carry. In 24-hour mode (control bit 0 = 1), hours count 0x00 to 0x23, and the step from 0x23 to 0x00 carries into the date.
- R4: In 12-hour mode (control bit 0 = 0), hour bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag. Stepping from 11 to 12 toggles the PM flag, and 12 steps to 01 with PM unchanged. Only PM 11 (0x31) to AM 12 (0x12) carries into the date.
- R5: Day of month wraps to 0x01 after 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after 0x30 in months 04, 06, 09 and 11. In month 02 it wraps after 0x29 when the year register's bit 15 leap flag is set, and after 0x28 when it is clear.
- R6: Month wraps from 0x12 to 0x01 and carries into the year, which wraps from 0x99 to 0x00. On every year step the leap flag is set to ((year + 1970) mod 4 == 0).
- R7: The weekday counts 0 to 6, wraps to 0, and advances on every date carry.
- R8: Address map: 0 seconds (bits 6:0), 1 minutes (6:0), 2 hours (5:0), 3 weekday (2:0), 4 day (5:0), 5 month (4:0), 6 year (7:0, leap flag in bit 15). Writes go only to shadow registers, and other bits are dropped. Writing address 7 with bit 15 set loads all seven shadow fields into the live counters in one cycle.
- R9: Address 7 always reads 0x0000. Address 8 is the control register, and its bit 0 reads back as written.
- R10: rdata holds the value of the addressed register in the cycle after rd_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable at the 32768 Hz rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
A wrong carry or a wrong month length stays hidden until the counters reach the boundary where it acts. It then shows as a wrong field on the next read and keeps spreading: a bad day carry shifts the month, the weekday and possibly the year from that second on. Because of this, each rollover boundary is loaded on purpose and read one second later. A prescaler that is not cleared on commit shows as a seconds value that is early or late by one, within the first TICK_DIV enables. A staging fault shows on the very next read, before or right after the commit.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int AW = 4;
  localparam int RW = 16;

  localparam logic [AW-1:0] A_SEC    = 4'd0;
  localparam logic [AW-1:0] A_MIN    = 4'd1;
  localparam logic [AW-1:0] A_HOUR   = 4'd2;
  localparam logic [AW-1:0] A_WDAY   = 4'd3;
  localparam logic [AW-1:0] A_MDAY   = 4'd4;
  localparam logic [AW-1:0] A_MON    = 4'd5;
  localparam logic [AW-1:0] A_YEAR   = 4'd6;
  localparam logic [AW-1:0] A_COMMIT = 4'd7;
  localparam logic [AW-1:0] A_CTRL   = 4'd8;

  typedef struct packed {
    logic       leap;
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] mday;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{leap: 1'b0, year: 8'h00, mon: 5'h01, mday: 6'h01,
                                 wday: 3'd0, hour: 6'h00, min: 7'h00, sec: 7'h00};

  // BCD increment of a two-digit value; no wrap handling here.
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last valid day of a BCD month.
  function automatic logic [5:0] month_last(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // (offset + 1970) mod 4 == 0  <=>  offset mod 4 == 2; offset = 10t+u => (2t+u) mod 4.
  function automatic logic leap_of(input logic [7:0] y);
    logic [5:0] s;
    s = {1'b0, y[7:4], 1'b0} + {2'b0, y[3:0]};
    return s[1:0] == 2'b10;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic sec_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign sec_tick = en && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (en)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r2_clear_on_commit: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/rtc_cal_shadow.sv
module rtc_cal_shadow
  import rtc_cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] wdata,
  output cal_t          staged,
  output logic          mode24,
  output logic          commit
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[RW-2:8];

  assign commit = wr_en && (addr == A_COMMIT) && wdata[RW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= CAL_RESET;
      mode24 <= 1'b1;
    end else if (wr_en) begin
      case (addr)
        A_SEC:  staged.sec  <= wdata[6:0];
        A_MIN:  staged.min  <= wdata[6:0];
        A_HOUR: staged.hour <= wdata[5:0];
        A_WDAY: staged.wday <= wdata[2:0];
        A_MDAY: staged.mday <= wdata[5:0];
        A_MON:  staged.mon  <= wdata[4:0];
        A_YEAR: begin
          staged.year <= wdata[7:0];
          staged.leap <= wdata[RW-1];
        end
        A_CTRL: mode24 <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cal_t staged,
  input  logic sec_tick,
  input  logic mode24,
  output cal_t now
);
  cal_t nxt;
  logic sec_wrap, min_wrap, day_carry, mday_end, mon_wrap;
  logic [5:0] hour_nxt;

  assign sec_wrap  = (now.sec == 7'h59);
  assign min_wrap  = sec_wrap && (now.min == 7'h59);
  assign day_carry = min_wrap && (mode24 ? (now.hour == 6'h23) : (now.hour == 6'h31));
  assign mday_end  = (now.mday == month_last(now.mon, now.leap));
  assign mon_wrap  = day_carry && mday_end && (now.mon == 5'h12);

  always_comb begin
    if (mode24) begin
      hour_nxt = (now.hour == 6'h23) ? 6'h00 : 6'(bcd_inc8({2'b0, now.hour}));
    end else if (now.hour[4:0] == 5'h11) begin
      hour_nxt = {~now.hour[5], 5'h12};
    end else if (now.hour[4:0] == 5'h12) begin
      hour_nxt = {now.hour[5], 5'h01};
    end else begin
      hour_nxt = {now.hour[5], 5'(bcd_inc8({3'b0, now.hour[4:0]}))};
    end
  end

  always_comb begin
    nxt     = now;
    nxt.sec = sec_wrap ? 7'h00 : 7'(bcd_inc8({1'b0, now.sec}));
    if (sec_wrap) nxt.min  = (now.min == 7'h59) ? 7'h00 : 7'(bcd_inc8({1'b0, now.min}));
    if (min_wrap) nxt.hour = hour_nxt;
    if (day_carry) begin
      nxt.wday = (now.wday == 3'd6) ? 3'd0 : now.wday + 3'd1;
      nxt.mday = mday_end ? 6'h01 : 6'(bcd_inc8({2'b0, now.mday}));
      if (mday_end)
        nxt.mon = (now.mon == 5'h12) ? 5'h01 : 5'(bcd_inc8({3'b0, now.mon}));
    end
    if (mon_wrap) begin
      nxt.year = (now.year == 8'h99) ? 8'h00 : bcd_inc8(now.year);
      nxt.leap = leap_of(nxt.year);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           now <= CAL_RESET;
    else if (load)     now <= staged;
    else if (sec_tick) now <= nxt;
  end

  a_r8_commit_loads: assert property (@(posedge clk) disable iff (rst)
    load |=> (now == $past(staged)));
  a_r3_sec_bcd: assert property (@(posedge clk) disable iff (rst)
    (now.sec[3:0] <= 4'd9) && (now.sec <= 7'h59));
  a_r5_mday_valid: assert property (@(posedge clk) disable iff (rst)
    (now.mday != 6'h00) && (now.mday <= 6'h31));
  a_r7_wday_range: assert property (@(posedge clk) disable iff (rst)
    now.wday <= 3'd6);
  a_r6_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !load && mon_wrap) |=> (now.mon == 5'h01) && (now.mday == 6'h01));
endmodule

// File: rtl/bcd_cal_rtc.sv
module bcd_cal_rtc
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_32k,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata
);
  cal_t staged, now;
  logic mode24, commit, sec_tick;

  rtc_prescaler #(.DIV(TICK_DIV)) presc_i (
    .clk(clk), .rst(rst), .en(tick_32k), .clr(commit), .sec_tick(sec_tick)
  );

  rtc_cal_shadow shadow_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .staged(staged), .mode24(mode24), .commit(commit)
  );

  rtc_cal_counter counter_i (
    .clk(clk), .rst(rst), .load(commit), .staged(staged),
    .sec_tick(sec_tick), .mode24(mode24), .now(now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_SEC:   rdata <= RW'(now.sec);
        A_MIN:   rdata <= RW'(now.min);
        A_HOUR:  rdata <= RW'(now.hour);
        A_WDAY:  rdata <= RW'(now.wday);
        A_MDAY:  rdata <= RW'(now.mday);
        A_MON:   rdata <= RW'(now.mon);
        A_YEAR:  rdata <= {now.leap, 7'b0, now.year};
        A_CTRL:  rdata <= RW'(mode24);
        default: rdata <= '0;
      endcase
    end
  end

  a_r9_commit_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_COMMIT) |=> (rdata == '0));
  a_r10_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL) |=> (rdata == RW'(mode24)));
endmodule

// File: tb/bcd_cal_rtc_tb_top.sv
module bcd_cal_rtc_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_32k = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench time model
  int m_sec, m_min, m_hr, m_pm, m_wd, m_md, m_mo, m_yr, m_leap, m_24;

  always #4 clk = ~clk;

  bcd_cal_rtc #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int dim(input int mo, input int leap);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int exp_hour();
    return m_24 ? bcd(m_hr) : ((m_pm << 5) | bcd(m_hr));
  endfunction

  task automatic advance();
    bit day;
    day = 1'b0;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0;
        if (m_24) begin
          m_hr++;
          if (m_hr == 24) begin m_hr = 0; day = 1'b1; end
        end else if (m_hr == 11) begin
          m_hr = 12;
          if (m_pm == 1) begin m_pm = 0; day = 1'b1; end else m_pm = 1;
        end else if (m_hr == 12) m_hr = 1;
        else m_hr++;
      end
    end
    if (day) begin
      m_wd = (m_wd + 1) % 7;
      if (m_md == dim(m_mo, m_leap)) begin
        m_md = 1;
        if (m_mo == 12) begin
          m_mo = 1;
          m_yr = (m_yr + 1) % 100;
          m_leap = ((m_yr + 1970) % 4 == 0) ? 1 : 0;
        end else m_mo++;
      end else m_md++;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_32k = 1'b1;
      repeat (n) @(negedge clk);
      tick_32k = 1'b0;
    end
  endtask

  task automatic run_secs(input int n);
    ticks(n * DIV);
    for (int i = 0; i < n; i++) advance();
  endtask

  // stage the model time with junk in the unused bits, then commit (R8)
  task automatic load_model();
    int junk;
    wr(8, m_24);
    junk = int'($urandom_range(0, 127)) << 8;
    wr(0, junk | bcd(m_sec));
    wr(1, junk | bcd(m_min));
    wr(2, junk | exp_hour());
    wr(3, junk | m_wd);
    wr(4, junk | bcd(m_md));
    wr(5, junk | bcd(m_mo));
    wr(6, junk | (m_leap << 15) | bcd(m_yr));
    wr(7, 16'h8000);
  endtask

  task automatic cmp_all(input string req);
    int v;
    rd(0, v); chk(req, "sec", v, bcd(m_sec));
    rd(1, v); chk(req, "min", v, bcd(m_min));
    rd(2, v); chk(req, "hour", v, exp_hour());
    rd(3, v); chk(req, "wday", v, m_wd);
    rd(4, v); chk(req, "mday", v, bcd(m_md));
    rd(5, v); chk(req, "month", v, bcd(m_mo));
    rd(6, v); chk(req, "year", v, (m_leap << 15) | bcd(m_yr));
  endtask

  task automatic set_model(input int mode24, input int yr, input int leap, input int mo,
                           input int md, input int wd, input int hr, input int pm,
                           input int mi, input int s);
    m_24 = mode24; m_yr = yr; m_leap = leap; m_mo = mo; m_md = md; m_wd = wd;
    m_hr = hr; m_pm = pm; m_min = mi; m_sec = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R10 read latency
    set_model(1, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    cmp_all("R1");
    rd(8, v); chk("R1", "ctrl", v, 1);

    // R8 staging: shadow write is not visible until commit; junk bits dropped
    wr(0, 16'h7F35);
    rd(0, v); chk("R8", "sec before commit", v, 0);
    wr(7, 16'h0000);
    rd(0, v); chk("R8", "sec after commit without trigger bit", v, 0);
    wr(7, 16'h8000);
    rd(0, v); chk("R8", "sec after commit", v, 16'h35);
    rd(7, v); chk("R9", "commit reads zero", v, 0);

    // R2 prescaler cleared by commit
    set_model(1, 5, 0, 3, 10, 2, 8, 0, 30, 10);
    ticks(DIV - 1);
    load_model();
    ticks(DIV - 1);
    rd(0, v); chk("R2", "sec before full period", v, 16'h10);
    ticks(1);
    rd(0, v); chk("R2", "sec after full period", v, 16'h11);

    // R3 R6 R7 end of range year, 24-hour mode
    set_model(1, 99, 0, 12, 31, 6, 23, 0, 59, 59);
    load_model(); run_secs(1); cmp_all("R6");
    set_model(1, 1, 0, 12, 31, 3, 23, 0, 59, 59);
    load_model(); run_secs(1); cmp_all("R6");
    rd(6, v); chk("R6", "leap set entering 1972", v, 16'h8002);
    rd(3, v); chk("R7", "weekday after day carry", v, 4);

    // R5 month lengths
    set_model(1, 2, 1, 2, 28, 1, 23, 0, 59, 59);
    load_model(); run_secs(1); cmp_all("R5");
    rd(4, v); chk("R5", "leap Feb 29", v, 16'h29);
    set_model(1, 2, 1, 2, 29, 1, 23, 0, 59, 59);
    load_model(); run_secs(1); cmp_all("R5");
    set_model(1, 3, 0, 2, 28, 1, 23, 0, 59, 59);
    load_model(); run_secs(1); cmp_all("R5");
    rd(5, v); chk("R5", "non-leap Feb ends at 28", v, 16'h03);
    set_model(1, 3, 0, 4, 30, 5, 23, 0, 59, 59);
    load_model(); run_secs(1); cmp_all("R5");

    // R4 12-hour mode
    set_model(0, 10, 0, 6, 15, 6, 11, 1, 59, 59);
    load_model(); run_secs(1);
    rd(2, v); chk("R4", "PM11 to AM12", v, 16'h12);
    cmp_all("R4");
    set_model(0, 10, 0, 6, 15, 2, 11, 0, 59, 59);
    load_model(); run_secs(1);
    rd(2, v); chk("R4", "AM11 to PM12", v, 16'h32);
    set_model(0, 10, 0, 6, 15, 2, 12, 1, 59, 59);
    load_model(); run_secs(1);
    rd(2, v); chk("R4", "PM12 to PM01", v, 16'h21);
    rd(8, v); chk("R9", "ctrl reads 12-hour", v, 0);

    // R3 minute carry in 24-hour mode
    set_model(1, 20, 0, 7, 4, 0, 9, 0, 59, 58);
    load_model(); run_secs(3); cmp_all("R3");

    // random stimulus
    for (int it = 0; it < 40; it++) begin
      int pre;
      m_24 = int'($urandom_range(0, 1));
      m_yr = int'($urandom_range(0, 99));
      m_leap = int'($urandom_range(0, 1));
      m_mo = int'($urandom_range(1, 12));
      m_md = int'($urandom_range(1, dim(m_mo, m_leap)));
      m_wd = int'($urandom_range(0, 6));
      if (m_24) begin m_hr = int'($urandom_range(0, 23)); m_pm = 0; end
      else begin m_hr = int'($urandom_range(1, 12)); m_pm = int'($urandom_range(0, 1)); end
      m_min = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
      m_sec = int'($urandom_range(0, 59));
      pre = int'($urandom_range(0, DIV - 1));
      ticks(pre);
      load_model();
      cmp_all("R8");
      run_secs(int'($urandom_range(1, 120)));
      cmp_all("R3");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule